// File: doc/BRIEF.md
# Programmable Baud Divisor with Latch Access

This block derives the 16x oversampling strobe for a serial port from the system clock, and it holds the line control settings that the transmitter and receiver read. A 16-bit divisor sets the strobe period in input clock cycles. The rate follows from divisor = f_clk / (16 × baud). For example, with a 1.8432 MHz clock a divisor of 24 (0x0018) gives 4800 baud and a divisor of 48 (0x0030) gives 2400 baud.

Software writes the registers over a plain address, data and write-enable bus. The divisor is written one byte at a time: the low byte at address 0 and the high byte at address 1. These two addresses are shared with the port's data registers. They reach the divisor only while the latch-access bit (bit 7) of the line control register at address 3 is set. A typical sequence is:

1. Write 0x80 to address 3 to open the latch.
2. Write the two divisor bytes.
3. Write 0x03 to address 3. This selects 8 data bits, no parity and one stop bit, and it closes the latch.

Top module: `uart_rate_ctrl`

## Requirements
- R1: After reset, the divisor output is 0x0000, all line control outputs are 0, and no tick is produced.
- R2: A write to address 3 updates the line control outputs from the following cycle, using this mapping:
  - word length = data[1:0]
  - stop select = data[2]
  - parity mode = data[5:3]
  - latch access = data[7]
  - data bit 6 has no effect.
  - Writing 0x03 gives word length 3, with the other fields and latch access at 0.
- R3: While latch access is 1, a write to address 0 replaces divisor bits [7:0] and a write to address 1 replaces bits [15:8]. The other byte keeps its value. Without such a write, the divisor holds.
- R4: While latch access is 0, writes to addresses 0 and 1 change neither the divisor nor the timing of the tick.
- R5: For a nonzero divisor D with no intervening divisor write, the tick is high for exactly one cycle and repeats every D cycles. With D = 1 it is high in every cycle.
- R6: Any divisor byte write restarts the count from the new value, even when the value is unchanged. The first tick appears exactly D cycles after the cycle that presents the write.
- R7: While the divisor is 0, no tick is produced.
- R8: Writes to addresses other than 0, 1 and 3 change neither the divisor, nor the line control outputs, nor the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| tick16_o | output | 1 | One-cycle 16x oversample strobe |
| divisor_o | output | 16 | Current divisor value |
| word_len_o | output | 2 | Word length select |
| stop_sel_o | output | 1 | Stop bit select |
| parity_sel_o | output | 3 | Parity mode select |
| dl_access_o | output | 1 | Divisor latch access bit |

## Verification
The assertions assume that the write strobe, address and data are stable across each rising edge. They also assume that the block sees one register write per cycle. The period check further assumes that the divisor changes only through restarting byte writes, so every interval it measures follows an undisturbed count. The stimulus drives the bus half a cycle away from the sampling edge and holds each write for exactly one edge. It expects ticks only from the cycle after a restart, and it makes the ignored-write and stray-address writes in the middle of a running count, where a wrong restart would move the next tick.

// File: rtl/uart_rate_pkg.sv
package uart_rate_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic       dl_access;
    logic [2:0] parity;
    logic       stop_sel;
    logic [1:0] word_len;
  } line_ctl_t;

  // bit 6 deliberately not held
  function automatic line_ctl_t line_ctl_decode(input logic [BYTE_W-1:0] b);
    line_ctl_t r;
    r.dl_access = b[7];
    r.parity    = b[5:3];
    r.stop_sel  = b[2];
    r.word_len  = b[1:0];
    return r;
  endfunction
endpackage

// File: rtl/rate_regs.sv
module rate_regs
  import uart_rate_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned LCR_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output line_ctl_t         lcr_o,
  output logic [DIV_W-1:0]  div_q_o,
  output logic [DIV_W-1:0]  div_nxt_o,
  output logic              div_load_o
);
  localparam int unsigned NBYTES = DIV_W / BYTE_W;

  line_ctl_t         lcr_q;
  logic [NBYTES-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lcr_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(LCR_ADDR)) lcr_q <= line_ctl_decode(wdata_i);
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_div_byte
    logic [BYTE_W-1:0] byte_q;
    assign hit[g] = wr_en_i && lcr_q.dl_access && (addr_i == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (hit[g]) byte_q <= wdata_i;
    end
    assign div_q_o[g*BYTE_W +: BYTE_W]   = byte_q;
    assign div_nxt_o[g*BYTE_W +: BYTE_W] = hit[g] ? wdata_i : byte_q;
  end

  assign div_load_o = |hit;
  assign lcr_o      = lcr_q;
endmodule

// File: rtl/rate_counter.sv
module rate_counter #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // reload at 1 (or idle 0): a zero divisor parks the counter at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (cnt_q <= DIV_W'(1))          cnt_q <= div_i;
    else                                  cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = (cnt_q == DIV_W'(1));
endmodule

// File: rtl/uart_rate_ctrl.sv
module uart_rate_ctrl
  import uart_rate_pkg::*;
#(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned LCR_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              tick16_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [1:0]        word_len_o,
  output logic              stop_sel_o,
  output logic [2:0]        parity_sel_o,
  output logic              dl_access_o
);
  line_ctl_t        lcr;
  logic [DIV_W-1:0] div_q, div_nxt;
  logic             div_load;

  rate_regs #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .LCR_ADDR(LCR_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .lcr_o(lcr), .div_q_o(div_q), .div_nxt_o(div_nxt),
    .div_load_o(div_load)
  );

  rate_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(div_load), .load_val_i(div_nxt),
    .div_i(div_q), .tick_o(tick16_o)
  );

  assign divisor_o    = div_q;
  assign word_len_o   = lcr.word_len;
  assign stop_sel_o   = lcr.stop_sel;
  assign parity_sel_o = lcr.parity;
  assign dl_access_o  = lcr.dl_access;
endmodule

// File: rtl/uart_rate_ctrl_chk.sv
module uart_rate_ctrl_chk #(
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned LCR_ADDR = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              tick16_o,
  input logic [DIV_W-1:0]  divisor_o,
  input logic [1:0]        word_len_o,
  input logic              stop_sel_o,
  input logic [2:0]        parity_sel_o,
  input logic              dl_access_o
);
  localparam logic [DIV_W:0] GAP_MAX = '1;

  logic           div_wr, wr_lo, wr_hi, wr_lcr;
  logic [DIV_W:0] gap_q;
  logic           seen_q;

  assign wr_lo  = wr_en_i && dl_access_o && addr_i == ADDR_W'(0);
  assign wr_hi  = wr_en_i && dl_access_o && addr_i == ADDR_W'(1);
  assign wr_lcr = wr_en_i && addr_i == ADDR_W'(LCR_ADDR);
  assign div_wr = wr_lo || wr_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (div_wr)        seen_q <= 1'b0;
      else if (tick16_o) seen_q <= 1'b1;
      if (tick16_o)               gap_q <= (DIV_W+1)'(1);
      else if (gap_q != GAP_MAX)  gap_q <= gap_q + (DIV_W+1)'(1);
    end
  end

  p_lcr_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lcr |=> (word_len_o == $past(wdata_i[1:0]) && stop_sel_o == $past(wdata_i[2]) &&
                parity_sel_o == $past(wdata_i[5:3]) && dl_access_o == $past(wdata_i[7])));

  p_low_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> (divisor_o[7:0] == $past(wdata_i) && divisor_o[DIV_W-1:8] == $past(divisor_o[DIV_W-1:8])));

  p_high_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> (divisor_o[DIV_W-1:8] == $past(wdata_i) && divisor_o[7:0] == $past(divisor_o[7:0])));

  p_div_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_wr |=> $stable(divisor_o));

  p_single_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && divisor_o > DIV_W'(1) && !div_wr) |=> !tick16_o);

  p_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && seen_q) |-> (gap_q == {1'b0, divisor_o}));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr |=> (tick16_o == (divisor_o == DIV_W'(1))));

  p_zero_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_o == '0 && $past(divisor_o) == '0 && !$past(div_wr)) |-> !tick16_o);
endmodule

bind uart_rate_ctrl uart_rate_ctrl_chk #(
  .DIV_W(DIV_W), .ADDR_W(ADDR_W), .LCR_ADDR(LCR_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .tick16_o(tick16_o), .divisor_o(divisor_o),
  .word_len_o(word_len_o), .stop_sel_o(stop_sel_o), .parity_sel_o(parity_sel_o),
  .dl_access_o(dl_access_o)
);

// File: tb/uart_rate_ctrl_tb.sv
module uart_rate_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        tick;
  logic [15:0] divisor;
  logic [1:0]  wlen;
  logic        stop_sel;
  logic [2:0]  par;
  logic        dla;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit mon_on = 1'b0;
  int mon_start = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rate_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .tick16_o(tick), .divisor_o(divisor), .word_len_o(wlen), .stop_sel_o(stop_sel),
    .parity_sel_o(par), .dl_access_o(dla)
  );

  // monitor: pops expected tick cycles, flags any tick not in the queue
  always @(negedge clk) begin
    if (mon_on && cyc >= mon_start) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        n_checks++;
        if (!tick) begin
          n_errors++;
          $display("FAIL R5/R6 tick missing at cycle %0d: actual=%0b expected=1", cyc, tick);
        end
        void'(exp_q.pop_front());
      end else if (tick) begin
        n_checks++;
        n_errors++;
        $display("FAIL R4/R6/R7/R8 unexpected tick at cycle %0d: actual=1 expected=0", cyc);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write; optionally arm the scoreboard for n ticks of period d
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input int arm_d, input int arm_n);
    @(negedge clk); #1;
    if (arm_n > 0) begin
      mon_on = 1'b0;
      exp_q.delete();
      for (int k = 1; k <= arm_n; k++) exp_q.push_back(cyc + k * arm_d);
      mon_start = cyc + 1;
      mon_on = 1'b1;
    end
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin
      @(negedge clk); #1;
    end
    mon_on = 1'b0;
  endtask

  task automatic quiet_window(input int n);
    exp_q.delete();
    mon_start = cyc + 1;
    mon_on = 1'b1;
    repeat (n) @(negedge clk);
    #1;
    mon_on = 1'b0;
  endtask

  task automatic prog(input int d, input int n);
    mon_on = 1'b0;
    bus_wr(3'd3, 8'h80, 0, 0);
    bus_wr(3'd0, d[7:0], 0, 0);
    bus_wr(3'd1, d[15:8], d, n);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 divisor", divisor, 0);
    chk("R1 fields", {dla, par, stop_sel, wlen}, 0);
    quiet_window(20);

    // R2 line control mapping
    bus_wr(3'd3, 8'hBD, 0, 0);
    chk("R2 word_len", wlen, 1);
    chk("R2 stop", stop_sel, 1);
    chk("R2 parity", par, 7);
    chk("R2 access", dla, 1);
    bus_wr(3'd3, 8'h03, 0, 0);
    chk("R2 0x03", {dla, par, stop_sel, wlen}, 8'h03);
    bus_wr(3'd3, 8'h40, 0, 0);
    chk("R2 bit6 ignored", {dla, par, stop_sel, wlen}, 0);
    bus_wr(3'd3, 8'h80, 0, 0);
    chk("R2 0x80", {dla, par, stop_sel, wlen}, 8'h40);

    // R3/R5/R6 divisor 24
    prog(24, 6);
    chk("R3 div 24", divisor, 24);
    drain();
    prog(1, 10); drain();   // R5 every cycle
    prog(2, 8);  drain();

    // R3 byte halves
    bus_wr(3'd3, 8'h80, 0, 0);
    bus_wr(3'd0, 8'h03, 0, 0);
    chk("R3 low byte", divisor, 16'h0003);
    bus_wr(3'd1, 8'h01, 259, 3);
    chk("R3 high byte", divisor, 16'h0103);
    drain();
    bus_wr(3'd1, 8'h00, 3, 4);
    chk("R3 high only", divisor, 16'h0003);
    drain();

    // R4/R8 writes during a running count
    prog(5, 14);
    bus_wr(3'd3, 8'h03, 0, 0);
    bus_wr(3'd0, 8'hFF, 0, 0);
    bus_wr(3'd1, 8'hFF, 0, 0);
    chk("R4 divisor kept", divisor, 5);
    bus_wr(3'd3, 8'h80, 0, 0);
    bus_wr(3'd2, 8'h11, 0, 0);
    bus_wr(3'd4, 8'h22, 0, 0);
    bus_wr(3'd7, 8'hFF, 0, 0);
    chk("R8 divisor kept", divisor, 5);
    chk("R8 fields kept", {dla, par, stop_sel, wlen}, 8'h40);
    drain();

    // R6 restart mid-period with the same value
    prog(7, 2); drain();
    do @(negedge clk); while (!tick);
    bus_wr(3'd0, 8'h07, 7, 3);
    drain();

    // R7 divisor zero
    bus_wr(3'd0, 8'h00, 0, 0);
    bus_wr(3'd1, 8'h00, 0, 0);
    chk("R7 divisor zero", divisor, 0);
    quiet_window(100);

    // 2400 baud example
    prog(48, 4);
    drain();
    chk("R3 div 48", divisor, 48);

    finish_run();
  end
endmodule